// File: doc/BRIEF.md
# Frame-Referenced Clock Frequency Tracker

This block keeps a local 48 MHz bus sampling clock aligned with the host's frame timing. A frame decoder upstream gives it a one-cycle reference pulse for every valid start-of-frame packet. Frames arrive every millisecond, so about 48000 local cycles are expected between pulses. The block counts the real spacing of the pulses and compares it with that nominal value. It then nudges a signed oscillator trim code one step per frame. Tracking goes on for as long as pulses keep coming, so the host's clock, and not a fixed target, sets where the oscillator settles.

The trim step is coarse for large errors and fine for small ones. This lets an offset of about ±5000 ppm (±240 cycles per frame) be pulled in within the ten or so frames of a bus reset recovery period. Intervals far outside the expected spacing count as missed or spurious frames and are thrown away. A gap that runs far too long restarts the measurement. A locked flag reports a stable match with the host.

Top module: `sof_freq_tracker`

## Requirements
- R1: After reset the trim code is 0, the reported interval is 0, and both the locked flag and the error flag are low.
- R2: The first reference pulse after reset, after re-enable, or after a timeout only starts the count. It changes no output.
- R3: From the second pulse on, every pulse reports the number of clock cycles since the previous pulse on `interval_o`, one cycle after the pulse. This holds for rejected intervals too.
- R4: Let the error be the interval minus `NOMINAL`. An accepted interval with a positive error lowers the trim code. A negative error raises it. An error of zero leaves it unchanged.
- R5: The step size is `FINE_STEP` (1) when the error magnitude is at most `FINE_BAND` (16). Otherwise it is `COARSE_STEP` (4).
- R6: Every updated trim code is clamped to the signed range [`trim_lo`, `trim_hi`].
- R7: An interval whose error magnitude is larger than `win` is rejected. The trim code is held, the error flag is high for exactly the cycle after that pulse, and the locked flag is cleared. An error magnitude equal to `win` is accepted.
- R8: The locked flag rises after `LOCK_RUN` (3) consecutive measurements with an error magnitude of at most `LOCK_BAND` (2). An accepted measurement outside that band restarts the run but leaves the flag as it is.
- R9: If no pulse arrives within `TIMEOUT` cycles of the last one, the count restarts and waits for a new starting pulse. The trim code and the locked flag are held, and the consecutive run restarts.
- R10: While `enable` is low, pulses are ignored. The trim code is held, and the lock flag and the run are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Tracking enable; low stops measuring |
| sof_pulse | input | 1 | One-cycle pulse per valid start-of-frame |
| trim_lo | input | TRIM_W | Lowest allowed trim code, signed |
| trim_hi | input | TRIM_W | Highest allowed trim code, signed |
| win | input | CNT_W | Acceptance window on the error magnitude, in cycles |
| trim_o | output | TRIM_W | Signed oscillator trim code |
| interval_o | output | CNT_W | Last measured pulse spacing in cycles |
| locked_o | output | 1 | Stable match with the host frame rate |
| err_o | output | 1 | One-cycle flag for a rejected interval |

## Verification
Every result of this block is registered once, at the clock edge that samples the reference pulse. The trim code, interval, locked flag and error flag are therefore all due exactly one cycle after the pulse. The scoreboard's monitor notices the pulse at that edge and compares a quarter period later. It then checks one cycle further on that the error flag has dropped again. Enable changes are checked on the cycle after the edge that samples them.

// File: rtl/sof_trk_pkg.sv
package sof_trk_pkg;

  // Signed trim increment for a measured error (interval minus nominal).
  function automatic int signed step_toward(input int signed e, input int band,
                                            input int fine, input int coarse);
    int mag;
    int s;
    if (e == 0) return 0;
    mag = (e < 0) ? -e : e;
    s = (mag <= band) ? fine : coarse;
    return (e > 0) ? -s : s;
  endfunction

  // Clamp into [lo, hi]; the upper bound is applied first.
  function automatic int signed clamp(input int signed v, input int signed lo,
                                      input int signed hi);
    int signed r;
    r = v;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/sof_interval_counter.sv
module sof_interval_counter #(
  parameter int CNT_W   = 17,
  parameter int TIMEOUT = 96000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pulse,
  output logic             meas_fire,
  output logic [CNT_W-1:0] meas_val,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] TO_LIM = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  assign meas_fire = enable & pulse & armed;
  assign meas_val  = cnt;
  assign timeout_o = enable & ~pulse & armed & (cnt >= TO_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!enable) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (pulse) begin
      cnt   <= CNT_W'(1);
      armed <= 1'b1;
    end else if (timeout_o) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (armed) begin
      cnt   <= cnt + CNT_W'(1);
    end
  end

  assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TO_LIM);

  assert_disarm_after_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> (cnt == '0));

  assert_idle_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));

endmodule

// File: rtl/sof_trim_stepper.sv
module sof_trim_stepper
  import sof_trk_pkg::*;
#(
  parameter int TRIM_W      = 8,
  parameter int EW          = 18,
  parameter int FINE_BAND   = 16,
  parameter int FINE_STEP   = 1,
  parameter int COARSE_STEP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic signed [EW-1:0]     err_i,
  input  logic signed [TRIM_W-1:0] lim_lo,
  input  logic signed [TRIM_W-1:0] lim_hi,
  output logic signed [TRIM_W-1:0] trim_o
);
  logic signed [TRIM_W-1:0] trim_d;

  always_comb begin
    int signed nxt;
    nxt = int'(trim_o) + step_toward(int'(err_i), FINE_BAND, FINE_STEP, COARSE_STEP);
    nxt = clamp(nxt, int'(lim_lo), int'(lim_hi));
    trim_d = TRIM_W'(nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   trim_o <= '0;
    else if (upd) trim_o <= trim_d;
  end

  assert_trim_moves_on_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim_o) |-> $past(upd));

  assert_trim_in_limits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && ($past(lim_lo) <= $past(lim_hi))) |->
      (trim_o >= $past(lim_lo) && trim_o <= $past(lim_hi)));

endmodule

// File: rtl/sof_lock_monitor.sv
module sof_lock_monitor #(
  parameter int EW         = 18,
  parameter int LOCK_BAND  = 2,
  parameter int LOCK_RUN   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          clr_run,
  input  logic          meas_fire,
  input  logic          in_window,
  input  logic [EW-1:0] mag,
  output logic          locked_o
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_RUN);

  logic [RW-1:0] run;
  logic          close_hit;
  logic [RW-1:0] run_inc;

  assign close_hit = mag <= EW'(LOCK_BAND);
  assign run_inc   = (run == RUN_MAX) ? run : run + RW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      locked_o <= 1'b0;
    end else if (clr_all) begin
      run      <= '0;
      locked_o <= 1'b0;
    end else if (clr_run) begin
      run      <= '0;
    end else if (meas_fire) begin
      if (!in_window) begin
        run      <= '0;
        locked_o <= 1'b0;
      end else if (close_hit) begin
        run <= run_inc;
        if (run_inc == RUN_MAX) locked_o <= 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  assert_lock_rise_on_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(meas_fire && in_window && close_hit));

  assert_lock_drop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> $past(clr_all || (meas_fire && !in_window)));

endmodule

// File: rtl/sof_freq_tracker.sv
module sof_freq_tracker #(
  parameter int NOMINAL     = 48000,
  parameter int TIMEOUT     = 2 * NOMINAL,
  parameter int CNT_W       = $clog2(TIMEOUT + 1),
  parameter int TRIM_W      = 8,
  parameter int FINE_BAND   = 16,
  parameter int FINE_STEP   = 1,
  parameter int COARSE_STEP = 4,
  parameter int LOCK_BAND   = 2,
  parameter int LOCK_RUN    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     sof_pulse,
  input  logic signed [TRIM_W-1:0] trim_lo,
  input  logic signed [TRIM_W-1:0] trim_hi,
  input  logic [CNT_W-1:0]         win,
  output logic signed [TRIM_W-1:0] trim_o,
  output logic [CNT_W-1:0]         interval_o,
  output logic                     locked_o,
  output logic                     err_o
);
  localparam int EW = CNT_W + 1;

  logic             meas_fire;
  logic [CNT_W-1:0] meas_val;
  logic             timeout_ev;
  logic signed [EW-1:0] err_val;
  logic [EW-1:0]    err_mag;
  logic             in_window;
  logic             accept;

  sof_interval_counter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pulse(sof_pulse),
    .meas_fire(meas_fire), .meas_val(meas_val), .timeout_o(timeout_ev)
  );

  assign err_val   = $signed({1'b0, meas_val}) - EW'(NOMINAL);
  assign err_mag   = err_val[EW-1] ? EW'(-err_val) : EW'(err_val);
  assign in_window = err_mag <= {1'b0, win};
  assign accept    = meas_fire & in_window;

  sof_trim_stepper #(
    .TRIM_W(TRIM_W), .EW(EW), .FINE_BAND(FINE_BAND),
    .FINE_STEP(FINE_STEP), .COARSE_STEP(COARSE_STEP)
  ) u_trim (
    .clk(clk), .rst_n(rst_n), .upd(accept), .err_i(err_val),
    .lim_lo(trim_lo), .lim_hi(trim_hi), .trim_o(trim_o)
  );

  sof_lock_monitor #(.EW(EW), .LOCK_BAND(LOCK_BAND), .LOCK_RUN(LOCK_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .clr_all(!enable), .clr_run(timeout_ev),
    .meas_fire(meas_fire), .in_window(in_window), .mag(err_mag),
    .locked_o(locked_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval_o <= '0;
      err_o      <= 1'b0;
    end else begin
      err_o <= meas_fire & ~in_window;
      if (meas_fire) interval_o <= meas_val;
    end
  end

  assert_err_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(meas_fire && !in_window));

  assert_err_holds_trim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(trim_o));

  assert_interval_on_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(interval_o) |-> $past(meas_fire));

  assert_disabled_holds_trim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> $stable(trim_o));

endmodule

// File: tb/sim_sof_freq_tracker.sv
module sim_sof_freq_tracker;
  localparam int PERIOD = 10;
  localparam int NOM    = 200;
  localparam int TO     = 400;
  localparam int CW     = $clog2(TO + 1);
  localparam int WIN    = 40;
  localparam int LO     = -20;
  localparam int HI     = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic sof = 1'b0;
  logic signed [7:0] trim_lo = 8'(LO);
  logic signed [7:0] trim_hi = 8'(HI);
  logic [CW-1:0] win = CW'(WIN);
  logic signed [7:0] trim_o;
  logic [CW-1:0] interval_o;
  logic locked_o, err_o;

  always #(PERIOD/2) clk = ~clk;

  sof_freq_tracker #(.NOMINAL(NOM), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(en), .sof_pulse(sof),
    .trim_lo(trim_lo), .trim_hi(trim_hi), .win(win),
    .trim_o(trim_o), .interval_o(interval_o), .locked_o(locked_o), .err_o(err_o)
  );

  int compared = 0;
  int mismatched = 0;

  // Reference model state
  bit m_en = 1, m_armed = 0, m_locked = 0;
  int m_trim = 0, m_int = 0, m_run = 0;

  int   q_trim[$], q_int[$];
  bit   q_lock[$], q_err[$];
  string q_tag[$];

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: pulse n cycles after the previous one, predict the outcome.
  task automatic pulse_after(input int n, input string tag);
    int e, mag, st;
    bit errx;
    errx = 0;
    repeat (n - 1) @(negedge clk);
    sof = 1'b1;
    if (m_en) begin
      if (!m_armed || n > TO) begin
        m_armed = 1;
        m_run = 0;
      end else begin
        m_int = n;
        e = n - NOM;
        mag = (e < 0) ? -e : e;
        if (mag > WIN) begin
          errx = 1; m_locked = 0; m_run = 0;
        end else begin
          st = (mag > 16) ? 4 : 1;
          if (e > 0) m_trim = m_trim - st;
          else if (e < 0) m_trim = m_trim + st;
          if (m_trim > HI) m_trim = HI;
          if (m_trim < LO) m_trim = LO;
          if (mag <= 2) begin
            if (m_run < 3) m_run++;
            if (m_run == 3) m_locked = 1;
          end else m_run = 0;
        end
      end
    end
    q_trim.push_back(m_trim); q_int.push_back(m_int);
    q_lock.push_back(m_locked); q_err.push_back(errx); q_tag.push_back(tag);
    @(negedge clk);
    sof = 1'b0;
  endtask

  // Monitor: compare one cycle after each sampled pulse.
  initial begin
    forever begin
      @(posedge clk);
      if (sof === 1'b1) begin
        #(PERIOD/4);
        if (q_tag.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R3: actual result with no expectation expected none queued");
        end else begin
          string t;
          t = q_tag.pop_front();
          check({t, " trim"}, int'(trim_o), q_trim.pop_front());
          check({t, " interval"}, int'(interval_o), q_int.pop_front());
          check({t, " locked"}, int'(locked_o), int'(q_lock.pop_front()));
          check({t, " err"}, int'(err_o), int'(q_err.pop_front()));
        end
        @(posedge clk);
        #(PERIOD/4);
        check("R7 err one cycle", int'(err_o), 0);
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trim", int'(trim_o), 0);
    check("R1 interval", int'(interval_o), 0);
    check("R1 locked", int'(locked_o), 0);
    check("R1 err", int'(err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    pulse_after(10, "R2 first pulse");
    pulse_after(190, "R5 fine up");
    pulse_after(170, "R5 coarse up");
    pulse_after(170, "R4 coarse up");
    pulse_after(170, "R6 clamp high");
    pulse_after(170, "R6 held at high");
    pulse_after(216, "R5 fine band edge down");
    pulse_after(217, "R5 coarse down");
    pulse_after(200, "R8 run 1");
    pulse_after(200, "R8 run 2");
    pulse_after(200, "R8 locked");
    pulse_after(201, "R8 close keeps lock");
    pulse_after(205, "R8 outside band keeps lock");
    pulse_after(260, "R7 reject high");
    pulse_after(241, "R7 reject window plus one");
    pulse_after(240, "R7 accept window edge");
    pulse_after(160, "R7 accept window low edge");
    pulse_after(TO + 50, "R9 timeout restarts");
    pulse_after(200, "R9 first after timeout");
    pulse_after(200, "R8 relock 2");
    pulse_after(200, "R8 relock 3");

    @(negedge clk);
    en = 1'b0; m_en = 0; m_armed = 0; m_run = 0; m_locked = 0;
    @(negedge clk);
    check("R10 lock cleared", int'(locked_o), 0);
    pulse_after(200, "R10 ignored while disabled");
    pulse_after(195, "R10 ignored again");
    en = 1'b1; m_en = 1;
    pulse_after(200, "R2 first after enable");
    pulse_after(195, "R4 up after enable");

    for (int i = 0; i < 8; i++) pulse_after(240, "R6 clamp low");

    repeat (5) @(negedge clk);
    if (q_tag.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R3: actual %0d pending expected 0", q_tag.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule